// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of the serial bus of a small flash device. The bus runs in SPI mode 0 or mode 3. The block samples the serial input on rising SCK edges and changes the serial output on falling SCK edges. The first byte of each chip-select frame is an opcode. The block gathers the address, data and filler bytes that follow it. Read frames stream bytes out of an internal register array, and status frames return the ready flag.

Byte-program and sector-erase frames are checked when chip select is released. A frame that is well formed becomes a one-cycle request to a separate write sequencer. That sequencer reports its activity back through `busy` and writes the array through a plain write port.

All pins are sampled in the system clock domain through short synchronizers, and the block detects SCK and CS edges there. SCK must therefore stay well below the system clock rate. The pad tri-state is built outside the block from `so` and `so_oe`.

Top module: `flash_front`

## Requirements
- R1: A read frame is opcode 8'hFF, three address bytes (MSB first, low log2(MEM_DEPTH) bits used), then two filler bytes. The byte at that address is driven MSB first, starting on the falling SCK edge after the 48th rising edge.
- R2: While SCK keeps toggling, each following read byte comes from the next address. After address MEM_DEPTH-1 the read continues at address 0.
- R3: Opcode 8'h9F returns a status byte MSB first, repeated for as long as clocks continue. Bits 7..1 are 0 and bit 0 is 1 when ready and 0 when `busy` is high. `busy` is sampled as each status byte begins.
- R4: `so_oe` is low except while read or status bits are being driven. Within a few system clocks of CS going high, `so_oe` returns low.
- R5: An erase frame is 8'h20, A1, A2, filler, 8'hD0, filler. On CS rising after exactly 48 rising SCK edges, the block raises `req_valid` for one cycle with `req_erase`=1 and `req_addr`={A1,A2,8'h00}.
- R6: A program frame is 8'h10, A1, A2, A3, D, filler. On CS rising after exactly 48 rising SCK edges, the block raises `req_valid` for one cycle with `req_erase`=0, `req_addr`={A1,A2,A3} and `req_data`=D.
- R7: No request is issued for a frame that is shorter or longer than 48 bits, for an erase whose fifth byte is not 8'hD0, or for any other opcode.
- R8: A read opcode received while `busy` is high is ignored, and `so_oe` stays low for the whole frame.
- R9: Mode 0 (SCK idle low) and mode 3 (SCK idle high) frames behave the same.
- R10: When `mem_we` is high on a clock edge, `mem_wdata` is stored at `mem_waddr`, and later reads return it.
- R11: After reset `so_oe` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for the `so` pad |
| busy | input | 1 | High while the write sequencer is programming or erasing |
| mem_we | input | 1 | Array write strobe from the write sequencer |
| mem_waddr | input | log2(MEM_DEPTH) | Array write address |
| mem_wdata | input | 8 | Array write data |
| req_valid | output | 1 | One-cycle pulse for an accepted program or erase frame |
| req_erase | output | 1 | 1 for a sector erase, 0 for a byte program |
| req_addr | output | 24 | Target address of the request |
| req_data | output | 8 | Byte to program |

## Verification
The assertions watch these rules on every cycle:
- `so_oe` falls once the frame is deselected, and it is never high without an active output mode.
- The read pointer wraps from the top address to zero.
- Every request is a single-cycle pulse that follows a frame of exactly six whole bytes, and an erase request always follows the confirm byte.
- A read opcode seen while busy never arms a read.

Only the bench scenarios can show the rest:
- the data and its alignment at the 48th edge, in both SPI modes;
- the status value following `busy` byte by byte;
- the exact request fields;
- the rejection of short, long, unconfirmed and unknown frames.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [7:0] OP_READ    = 8'hFF;
  localparam logic [7:0] OP_STATUS  = 8'h9F;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROGRAM = 8'h10;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;

  // byte positions inside a frame; behaviour depends on them
  localparam logic [2:0] FRAME_LEN    = 3'd6;
  localparam logic [2:0] RD_LAST_HDR  = 3'd5;
  localparam logic [2:0] CNT_SAT      = 3'd7;

  typedef enum logic [1:0] {
    OUT_IDLE = 2'd0,
    OUT_DATA = 2'd1,
    OUT_STAT = 2'd2
  } out_mode_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic si_s
);
  logic [STAGES-1:0] sck_pipe, cs_pipe, si_pipe;
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      cs_pipe  <= '1;
      si_pipe  <= '0;
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-2:0], sck};
      cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
      si_pipe  <= {si_pipe[STAGES-2:0], si};
      sck_q    <= sck_pipe[STAGES-1];
      cs_q     <= cs_pipe[STAGES-1];
    end
  end

  assign sel      = ~cs_pipe[STAGES-1];
  assign sck_rise = sel &  sck_pipe[STAGES-1] & ~sck_q;
  assign sck_fall = sel & ~sck_pipe[STAGES-1] &  sck_q;
  assign cs_rise  = cs_pipe[STAGES-1] & ~cs_q;
  assign si_s     = si_pipe[STAGES-1];
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import flash_fe_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sck_rise,
  input  logic          cs_rise,
  input  logic          si_s,
  input  logic          busy,
  output logic          start_rd,
  output logic          start_st,
  output logic [AW-1:0] rd_addr,
  output logic          req_valid,
  output logic          req_erase,
  output logic [23:0]   req_addr,
  output logic [7:0]    req_data
);
  logic [2:0] bit_q, bit_d, nb_q, nb_d;
  logic [6:0] sh_q, sh_d;
  logic [7:0] op_q, op_d, a1_q, a1_d, a2_q, a2_d, a3_q, a3_d, b4_q, b4_d;
  logic       rd_ok_q, rd_ok_d, st_d, rdgo_d, rq_d, rq_erase_d;
  logic [23:0] rq_addr_d;
  logic [7:0]  rq_data_d;
  logic [7:0]  byte_val;
  logic        frame_ok;

  assign byte_val = {sh_q, si_s};
  assign frame_ok = (nb_q == FRAME_LEN) && (bit_q == 3'd0) &&
                    ((op_q == OP_PROGRAM) ||
                     ((op_q == OP_ERASE) && (b4_q == OP_CONFIRM)));

  always_comb begin
    bit_d = bit_q; nb_d = nb_q; sh_d = sh_q;
    op_d = op_q; a1_d = a1_q; a2_d = a2_q; a3_d = a3_q; b4_d = b4_q;
    rd_ok_d = rd_ok_q; st_d = 1'b0; rdgo_d = 1'b0;
    rq_d = cs_rise & frame_ok;
    rq_erase_d = req_erase; rq_addr_d = req_addr; rq_data_d = req_data;
    if (rq_d) begin
      rq_erase_d = (op_q == OP_ERASE);
      rq_addr_d  = rq_erase_d ? {a1_q, a2_q, 8'h00} : {a1_q, a2_q, a3_q};
      rq_data_d  = b4_q;
    end
    if (!sel) begin
      bit_d = 3'd0; nb_d = 3'd0; rd_ok_d = 1'b0;
    end else if (sck_rise) begin
      bit_d = bit_q + 3'd1;
      sh_d  = {sh_q[5:0], si_s};
      if (bit_q == 3'd7) begin
        if (nb_q != CNT_SAT) nb_d = nb_q + 3'd1;
        case (nb_q)
          3'd0: begin
            op_d    = byte_val;
            rd_ok_d = (byte_val == OP_READ) && !busy;
            st_d    = (byte_val == OP_STATUS);
          end
          3'd1: a1_d = byte_val;
          3'd2: a2_d = byte_val;
          3'd3: a3_d = byte_val;
          3'd4: b4_d = byte_val;
          RD_LAST_HDR: rdgo_d = rd_ok_q;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0; nb_q <= '0; sh_q <= '0;
      op_q <= '0; a1_q <= '0; a2_q <= '0; a3_q <= '0; b4_q <= '0;
      rd_ok_q <= 1'b0; start_st <= 1'b0; start_rd <= 1'b0;
      req_valid <= 1'b0; req_erase <= 1'b0; req_addr <= '0; req_data <= '0;
    end else begin
      bit_q <= bit_d; nb_q <= nb_d; sh_q <= sh_d;
      op_q <= op_d; a1_q <= a1_d; a2_q <= a2_d; a3_q <= a3_d; b4_q <= b4_d;
      rd_ok_q <= rd_ok_d; start_st <= st_d; start_rd <= rdgo_d;
      req_valid <= rq_d; req_erase <= rq_erase_d;
      req_addr <= rq_addr_d; req_data <= rq_data_d;
    end
  end

  assign rd_addr = AW'({a1_q, a2_q, a3_q});

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  p_req_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($past(nb_q) == FRAME_LEN && $past(bit_q) == 3'd0));
  p_erase_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_erase) |-> ($past(b4_q) == OP_CONFIRM));
  p_busy_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sck_rise && bit_q == 3'd7 && nb_q == 3'd0 && busy) |=> !rd_ok_q);
endmodule

// File: rtl/read_engine.sv
module read_engine
  import flash_fe_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sck_fall,
  input  logic          start_rd,
  input  logic          start_st,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [7:0]    mem_wdata,
  output logic          so,
  output logic          so_oe
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  out_mode_e     mode_q, mode_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [2:0]    obit_q, obit_d;
  logic [7:0]    out_q, out_d;
  logic          oe_q, oe_d;
  logic [7:0]    stat_byte;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  assign stat_byte = {7'd0, ~busy};

  always_comb begin
    mode_d = mode_q; ptr_d = ptr_q; obit_d = obit_q; out_d = out_q; oe_d = oe_q;
    if (!sel) begin
      mode_d = OUT_IDLE; oe_d = 1'b0; obit_d = 3'd0;
    end else if (start_rd) begin
      mode_d = OUT_DATA; ptr_d = rd_addr; obit_d = 3'd0;
    end else if (start_st) begin
      mode_d = OUT_STAT; obit_d = 3'd0;
    end else if (sck_fall && mode_q != OUT_IDLE) begin
      obit_d = obit_q + 3'd1;
      oe_d   = 1'b1;
      if (obit_q == 3'd0) begin
        if (mode_q == OUT_DATA) begin
          out_d = mem[ptr_q];
          ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end else begin
          out_d = stat_byte;
        end
      end else begin
        out_d = {out_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OUT_IDLE; ptr_q <= '0; obit_q <= '0; out_q <= '0; oe_q <= 1'b0;
    end else begin
      mode_q <= mode_d; ptr_q <= ptr_d; obit_q <= obit_d; out_q <= out_d; oe_q <= oe_d;
    end
  end

  assign so    = out_q[7];
  assign so_oe = oe_q;

  p_oe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !so_oe);
  p_oe_needs_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (mode_q != OUT_IDLE));
  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !start_rd && !start_st && sck_fall && mode_q == OUT_DATA &&
     obit_q == 3'd0 && ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/flash_front.sv
module flash_front #(
  parameter int MEM_DEPTH   = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          busy,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [7:0]    mem_wdata,
  output logic          req_valid,
  output logic          req_erase,
  output logic [23:0]   req_addr,
  output logic [7:0]    req_data
);
  logic sel, sck_rise, sck_fall, cs_rise, si_s, start_rd, start_st;
  logic [AW-1:0] rd_addr;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .si_s(si_s)
  );

  cmd_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise),
    .cs_rise(cs_rise), .si_s(si_s), .busy(busy),
    .start_rd(start_rd), .start_st(start_st), .rd_addr(rd_addr),
    .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data)
  );

  read_engine #(.DEPTH(MEM_DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_fall(sck_fall),
    .start_rd(start_rd), .start_st(start_st), .rd_addr(rd_addr),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .so(so), .so_oe(so_oe)
  );
endmodule

// File: tb/flash_front_test.sv
`timescale 1ns/1ps
module flash_front_test;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si, busy, mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0] mem_wdata;
  logic so, so_oe, req_valid, req_erase;
  logic [23:0] req_addr;
  logic [7:0] req_data;

  int checks = 0, errors = 0, req_cnt = 0;
  logic mode3 = 1'b0;
  logic [7:0] fb [8];
  logic [7:0] rxb [32];
  logic hdr_oe, dat_oe_all;

  always #2 clk = ~clk;

  flash_front #(.MEM_DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .busy(busy), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data)
  );

  always @(negedge clk) if (rst_n && req_valid) req_cnt++;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) ^ 8'h5A);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      inout logic oe_any, inout logic oe_all);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so; oe_any |= so_oe; oe_all &= so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  // nc command bytes from fb, then nr bytes clocked in with SI=0 into rxb
  task automatic frame(int nc, int nr);
    logic [7:0] r;
    hdr_oe = 1'b0; dat_oe_all = 1'b1;
    sck = mode3; @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nc; k++) begin
      logic dummy_all = 1'b1;
      xfer(fb[k], r, hdr_oe, dummy_all);
    end
    for (int k = 0; k < nr; k++) begin
      logic dummy_any = 1'b0;
      xfer(8'h00, r, dummy_any, dat_oe_all);
      rxb[k] = r;
    end
    @(negedge clk); if (!mode3) sck = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic set6(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                      logic [7:0] b3, logic [7:0] b4, logic [7:0] b5);
    fb[0] = b0; fb[1] = b1; fb[2] = b2; fb[3] = b3; fb[4] = b4; fb[5] = b5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; busy = 1'b0;
    mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    repeat (5) @(negedge clk);
    check("R11 so_oe after reset", 32'(so_oe), 0);
    check("R11 req_valid after reset", 32'(req_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: fill array through the write port
    for (int i = 0; i < DEPTH; i++) begin
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = pat(i);
      @(negedge clk);
    end
    mem_we = 1'b0;

    // R1 R2 R4 R9: read from every start address, alternating modes
    for (int a = 0; a < DEPTH; a++) begin
      mode3 = a[0];
      set6(8'hFF, 8'h00, 8'h00, 8'(a), 8'h00, 8'h00);
      frame(6, 3);
      check("R4 no drive during read header", 32'(hdr_oe), 0);
      check("R1 R9 drive during read data", 32'(dat_oe_all), 1);
      for (int k = 0; k < 3; k++)
        check("R1 R2 R9 read byte", 32'(rxb[k]), 32'(pat((a + k) % DEPTH)));
      check("R4 released after CS high", 32'(so_oe), 0);
    end

    // R2: long read across the top of the array
    mode3 = 1'b0;
    set6(8'hFF, 8'h00, 8'h00, 8'(DEPTH - 2), 8'h00, 8'h00);
    frame(6, 20);
    for (int k = 0; k < 20; k++)
      check("R2 wrap read", 32'(rxb[k]), 32'(pat((DEPTH - 2 + k) % DEPTH)));

    // R3: status, ready and busy, both modes
    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      busy = 1'b0; fb[0] = 8'h9F; frame(1, 3);
      for (int k = 0; k < 3; k++) check("R3 status ready", 32'(rxb[k]), 32'h01);
      busy = 1'b1; frame(1, 2);
      for (int k = 0; k < 2; k++) check("R3 status busy", 32'(rxb[k]), 32'h00);
    end

    // R8: read while busy is ignored
    mode3 = 1'b0; busy = 1'b1;
    set6(8'hFF, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00);
    frame(6, 3);
    check("R8 no drive for read while busy", 32'(hdr_oe | ~dat_oe_all & 1'b0), 0);
    check("R8 data phase not driven", 32'(dat_oe_all), 0);
    busy = 1'b0;

    // R6: program frames
    for (int t = 0; t < 6; t++) begin
      logic [7:0] x1, x2, x3, d;
      mode3 = t[0];
      x1 = 8'(t * 17 + 1); x2 = 8'(t * 41 + 3); x3 = 8'(t * 73 + 9); d = 8'(t * 53 + 11);
      set6(8'h10, x1, x2, x3, d, 8'hC3);
      n0 = req_cnt; frame(6, 0);
      check("R6 one request", 32'(req_cnt - n0), 1);
      check("R6 kind", 32'(req_erase), 0);
      check("R6 address", 32'(req_addr), 32'({x1, x2, x3}));
      check("R6 data", 32'(req_data), 32'(d));
    end

    // R5: erase frames
    for (int t = 0; t < 6; t++) begin
      logic [7:0] x1, x2;
      mode3 = t[0];
      x1 = 8'(t * 23 + 5); x2 = 8'(t * 97 + 2);
      set6(8'h20, x1, x2, 8'h77, 8'hD0, 8'h11);
      n0 = req_cnt; frame(6, 0);
      check("R5 one request", 32'(req_cnt - n0), 1);
      check("R5 kind", 32'(req_erase), 1);
      check("R5 sector address", 32'(req_addr), 32'({x1, x2, 8'h00}));
    end

    // R7: rejected frames
    mode3 = 1'b0;
    for (int t = 0; t < 4; t++) begin
      logic [7:0] cf;
      cf = (t == 0) ? 8'hD1 : (t == 1) ? 8'h00 : (t == 2) ? 8'hFF : 8'h50;
      set6(8'h20, 8'h01, 8'h02, 8'h00, cf, 8'h00);
      n0 = req_cnt; frame(6, 0);
      check("R7 bad confirm rejected", 32'(req_cnt - n0), 0);
    end
    set6(8'h10, 8'h01, 8'h02, 8'h03, 8'h44, 8'h00);
    n0 = req_cnt; frame(5, 0);
    check("R7 short frame rejected", 32'(req_cnt - n0), 0);
    fb[6] = 8'h00;
    n0 = req_cnt; frame(7, 0);
    check("R7 long frame rejected", 32'(req_cnt - n0), 0);
    set6(8'h30, 8'h01, 8'h02, 8'h03, 8'hD0, 8'h00);
    n0 = req_cnt; frame(6, 0);
    check("R7 unknown opcode rejected", 32'(req_cnt - n0), 0);

    // R10: overwrite one location and read it back
    @(negedge clk); mem_we = 1'b1; mem_waddr = AW'(5); mem_wdata = 8'hE1;
    @(negedge clk); mem_we = 1'b0;
    set6(8'hFF, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00);
    frame(6, 2);
    check("R10 written byte read back", 32'(rxb[0]), 32'hE1);
    check("R10 neighbour intact", 32'(rxb[1]), 32'(pat(6)));

    finish_run();
  end
endmodule